// File: doc/BRIEF.md
# SPI Master with Register Port

This block is a serial peripheral interface master that software or a DMA-style requester drives through four word registers. A control word sets the mode, selects one of three chip-select lines, sets their polarities and starts or ends a transfer. A data port sits in front of a 16-byte transmit queue and a 16-byte receive queue. A divisor register sets the serial clock, and a length register bounds a counted transfer.

While the transfer-active bit is set, each byte in the transmit queue is shifted out most significant bit first on MOSI. At the same time a byte is shifted in from MISO and stored in the receive queue. Status bits in the control word report the queue levels and a done condition, so a requester knows when to feed or drain the data port. In counted mode the block stops after the programmed number of bytes, releases chip select on its own and raises done.

Register word addresses are 0 (control/status), 1 (data), 2 (divisor) and 3 (length).

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the control/status word reads 0x0004_0000, meaning only bit 18 (transmit queue can accept) is set. The divisor reads 0, SCLK is low and all three chip-select outputs are high.
- R2: The control word sets the mode through bit 3 (CPOL) and bit 2 (CPHA). In every one of the four modes, each queued byte appears on MOSI most significant bit first, valid on the sampling edge. The sampling edge is the leading edge when CPHA=0 and the trailing edge when CPHA=1. The byte sampled from MISO on those same edges is stored in the receive queue, and the data port returns it in bits 7:0.
- R3: While transfer-active (bit 7) is low, SCLK rests at the CPOL level.
- R4: One SCLK period lasts as many core clocks as the divisor register value. Bit 0 of that register is ignored, so a written 7 acts as 6 and reads back as 6. SCLK high and low phases each last half the period.
- R5: A divisor of 0 gives the longest period, 65536 core clocks, so the high phase lasts 32768 clocks.
- R6: Bits 1:0 select chip-select line 0, 1 or 2. The value 3 selects none. The active level of line i is bit 21+i OR the common polarity bit 6. With transfer-active set, the selected line sits at its active level and every other line at the inverse of its own active level.
- R7: Writing a control word with bit 4 set empties the transmit queue, and with bit 5 set empties the receive queue. Flushed transmit bytes are never sent.
- R8: Each queue holds 16 bytes. A write to the data port while the transmit queue is full is dropped. A read of the data port while the receive queue is empty returns 0.
- R9: Status bit 17 is set while the receive queue holds data, and bit 18 while the transmit queue is not full. Bit 19 is set while the receive queue holds 12 or more bytes, and bit 20 while it holds 16. Shifting pauses while the receive queue is full.
- R10: Done (bit 16) is set while transfer-active is high, the shifter is idle with its last byte stored, and the transmit queue is empty. A data write clears done from the next cycle.
- R11: When bits 8 and 11 are both set, the block shifts exactly the number of bytes in the length register. It then holds all chip selects inactive and sets done, and any remaining transmit bytes stay queued.
- R12: Clearing transfer-active aborts any byte in progress, returns SCLK to the CPOL level and puts every chip select at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select lines, level per polarity bits |

## Verification
Register writes take effect at the clock edge that accepts them. Chip-select levels, SCLK idle level and status flags are therefore read at the falling edge straight after that write, and read data is sampled while the read strobe is still high, before the pop edge. Serial bytes finish 16 half-periods after they start. The bench does not predict an exact start cycle. Its monitor instead rebuilds each byte from MOSI on the sampling edges of the programmed mode and compares it with the queue the driver filled. Done is polled before the receive queue is read, because the stored byte lands one cycle after the last SCLK edge. Period checks count falling edges of the core clock across one SCLK high phase.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_CS  = 3;
    localparam int DIV_W   = 16;
    localparam int LEN_W   = 16;

    // register word addresses
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DATA = 2'd1,
        ADDR_DIV  = 2'd2,
        ADDR_LEN  = 2'd3
    } reg_addr_e;

    // control word bit positions
    localparam int P_SEL     = 0;
    localparam int P_CPHA    = 2;
    localparam int P_CPOL    = 3;
    localparam int P_FL_TX   = 4;
    localparam int P_FL_RX   = 5;
    localparam int P_POL_ALL = 6;
    localparam int P_ACTIVE  = 7;
    localparam int P_DMA     = 8;
    localparam int P_AUTO    = 11;
    localparam int P_DONE    = 16;
    localparam int P_RX_ANY  = 17;
    localparam int P_TX_ROOM = 18;
    localparam int P_RX_HIGH = 19;
    localparam int P_RX_FULL = 20;
    localparam int P_LINEPOL = 21;

    typedef struct packed {
        logic [NUM_CS-1:0] line_pol;
        logic              auto_cs;
        logic              dma_en;
        logic              active;
        logic              pol_all;
        logic              cpol;
        logic              cpha;
        logic [1:0]        sel;
    } ctrl_t;

    typedef struct packed {
        logic rx_full;
        logic rx_high;
        logic tx_room;
        logic rx_any;
        logic done;
    } stat_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.sel      = w[P_SEL+1:P_SEL];
        c.cpha     = w[P_CPHA];
        c.cpol     = w[P_CPOL];
        c.pol_all  = w[P_POL_ALL];
        c.active   = w[P_ACTIVE];
        c.dma_en   = w[P_DMA];
        c.auto_cs  = w[P_AUTO];
        c.line_pol = w[P_LINEPOL+NUM_CS-1:P_LINEPOL];
        return c;
    endfunction

    function automatic logic [31:0] encode_ctrl(input ctrl_t c, input stat_t s);
        logic [31:0] w;
        w = '0;
        w[P_SEL+1:P_SEL] = c.sel;
        w[P_CPHA]        = c.cpha;
        w[P_CPOL]        = c.cpol;
        w[P_POL_ALL]     = c.pol_all;
        w[P_ACTIVE]      = c.active;
        w[P_DMA]         = c.dma_en;
        w[P_AUTO]        = c.auto_cs;
        w[P_DONE]        = s.done;
        w[P_RX_ANY]      = s.rx_any;
        w[P_TX_ROOM]     = s.tx_room;
        w[P_RX_HIGH]     = s.rx_high;
        w[P_RX_FULL]     = s.rx_full;
        w[P_LINEPOL+NUM_CS-1:P_LINEPOL] = c.line_pol;
        return w;
    endfunction

    // half SCLK period in core clocks; divisor bit 0 dropped, zero means maximum
    function automatic logic [DIV_W-1:0] half_period(input logic [DIV_W-1:1] div_hi);
        logic [DIV_W-1:0] h;
        h = {1'b0, div_hi};
        if (div_hi == '0) h = {1'b1, {(DIV_W-1){1'b0}}};
        return h;
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,               // power of two
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = empty ? '0 : store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> $stable(level)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !flush) |=> (level == '0)); // R8

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_host_pkg::*;
#(
    localparam int EDGES  = 2 * BYTE_W,
    localparam int EDGE_W = $clog2(EDGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  half,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              busy,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    localparam logic [EDGE_W-1:0] LAST = EDGE_W'(EDGES - 1);

    logic [DIV_W-1:0]  tmr;
    logic [EDGE_W-1:0] edge_idx;
    logic              phase;
    logic [BYTE_W-1:0] tx_sr, rx_sr;
    logic              leading;

    assign leading = !edge_idx[0];
    assign sclk    = cpol ^ phase;
    assign mosi    = tx_sr[BYTE_W-1];

    always_ff @(posedge clk) begin
        byte_done <= 1'b0;
        if (rst || !enable) begin
            busy     <= 1'b0;
            phase    <= 1'b0;
            tmr      <= '0;
            edge_idx <= '0;
            if (rst) begin
                tx_sr   <= '0;
                rx_sr   <= '0;
                rx_byte <= '0;
            end
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                tx_sr    <= tx_byte;
                tmr      <= '0;
                edge_idx <= '0;
                phase    <= 1'b0;
            end
        end else if (tmr == half - 1'b1) begin
            tmr      <= '0;
            phase    <= ~phase;
            edge_idx <= edge_idx + 1'b1;
            if (leading) begin
                if (!cpha)               rx_sr <= {rx_sr[BYTE_W-2:0], miso};
                else if (edge_idx != '0) tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end else begin
                if (cpha)                rx_sr <= {rx_sr[BYTE_W-2:0], miso};
                else if (edge_idx != LAST) tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
            if (edge_idx == LAST) begin
                busy      <= 1'b0;
                byte_done <= 1'b1;
                rx_byte   <= cpha ? {rx_sr[BYTE_W-2:0], miso} : rx_sr;
            end
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (sclk == cpol || !$stable(cpol))); // R3

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int RX_HIGH   = (FIFO_DEPTH * 3) / 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);

    ctrl_t             ctrl_q;
    logic [DIV_W-1:1]  div_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  byte_cnt_q;

    logic wr_ctrl, wr_data, wr_div, wr_len, rd_data;
    logic flush_tx, flush_rx;
    logic auto_mode, cnt_hit, done_flag;

    logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
    logic [LVL_W-1:0]  tx_level_unused, rx_level;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              sh_start, sh_busy, sh_done;
    logic [NUM_CS-1:0] eff_pol;
    stat_t             stat;
    logic              unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:24], reg_wdata[20:12], reg_wdata[10:9]};

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_div   = reg_wr && (reg_addr == ADDR_DIV);
    assign wr_len   = reg_wr && (reg_addr == ADDR_LEN);
    assign rd_data  = reg_rd && (reg_addr == ADDR_DATA);
    assign flush_tx = wr_ctrl && reg_wdata[P_FL_TX];
    assign flush_rx = wr_ctrl && reg_wdata[P_FL_RX];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            len_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= decode_ctrl(reg_wdata);
            if (wr_div)  div_q  <= reg_wdata[DIV_W-1:1];
            if (wr_len)  len_q  <= reg_wdata[LEN_W-1:0];
        end
    end

    // bytes completed in the current counted transfer
    always_ff @(posedge clk) begin
        if (rst || !ctrl_q.active)     byte_cnt_q <= '0;
        else if (sh_done && auto_mode) byte_cnt_q <= byte_cnt_q + 1'b1;
    end

    assign auto_mode = ctrl_q.dma_en && ctrl_q.auto_cs;
    assign cnt_hit   = auto_mode && (byte_cnt_q == len_q);
    assign sh_start  = ctrl_q.active && !sh_busy && !sh_done && !tx_empty
                       && !rx_full && !cnt_hit;
    assign done_flag = ctrl_q.active && !sh_busy && !sh_done
                       && (auto_mode ? cnt_hit : tx_empty);

    spi_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_tx),
        .push  (wr_data),
        .din   (reg_wdata[BYTE_W-1:0]),
        .pop   (sh_start),
        .dout  (tx_head),
        .level (tx_level_unused),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_rx),
        .push  (sh_done),
        .din   (rx_byte),
        .pop   (rd_data),
        .dout  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_bit_engine i_engine (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl_q.active),
        .cpol      (ctrl_q.cpol),
        .cpha      (ctrl_q.cpha),
        .half      (half_period(div_q)),
        .start     (sh_start),
        .tx_byte   (tx_head),
        .busy      (sh_busy),
        .byte_done (sh_done),
        .rx_byte   (rx_byte),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .miso      (spi_miso)
    );

    // chip-select lines
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        logic line_on;
        assign eff_pol[i] = ctrl_q.line_pol[i] | ctrl_q.pol_all;
        assign line_on    = ctrl_q.active && (ctrl_q.sel == 2'(i)) && !cnt_hit;
        assign spi_cs[i]  = line_on ? eff_pol[i] : ~eff_pol[i];
    end

    always_comb begin
        stat.done    = done_flag;
        stat.rx_any  = !rx_empty;
        stat.tx_room = !tx_full;
        stat.rx_high = (rx_level >= LVL_W'(RX_HIGH));
        stat.rx_full = rx_full;
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = encode_ctrl(ctrl_q, stat);
            ADDR_DATA: reg_rdata = {{(32-BYTE_W){1'b0}}, rx_head};
            ADDR_DIV:  reg_rdata = {{(32-DIV_W){1'b0}}, div_q, 1'b0};
            default:   reg_rdata = {{(32-LEN_W){1'b0}}, len_q};
        endcase
    end

    AST_START_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(sh_busy) |-> !$past(tx_empty)); // R2
    AST_DONE_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_flag |-> (spi_sclk == ctrl_q.cpol)); // R10
    AST_AUTO_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && ctrl_q.active) |-> (byte_cnt_q <= len_q)); // R11
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.active |-> (spi_cs == ~eff_pol)); // R12

endmodule

// File: tb/test_spi_host_ctrl.sv
module test_spi_host_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [2:0]  spi_cs;

    int n_chk = 0, n_fail = 0;

    // scoreboard state
    logic [7:0] exp_q[$];
    logic       mon_cpol = 1'b0, mon_cpha = 1'b0;
    logic       prev_sclk = 1'b0;
    logic [7:0] mon_bits = 8'd0;
    int         mon_nb = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign spi_miso = ~spi_mosi;   // inverting loopback

    spi_host_ctrl i_spi_host_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs(spi_cs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: rebuild each byte from MOSI on the sampling edge of the mode
    always @(negedge clk) begin
        if (spi_sclk !== prev_sclk) begin
            if ((spi_sclk != mon_cpol) == !mon_cpha) begin
                mon_bits = {mon_bits[6:0], spi_mosi};
                mon_nb++;
                if (mon_nb == 8) begin
                    mon_nb = 0;
                    n_chk++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R2 unexpected MOSI byte actual %h expected none", mon_bits);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        if (mon_bits !== e) begin
                            n_fail++;
                            $display("FAIL R2 MOSI byte actual %h expected %h", mon_bits, e);
                        end
                    end
                end
            end
        end
        prev_sclk = spi_sclk;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: queue a byte, and its expectation when it is meant to go out
    task automatic send(input logic [7:0] b, input bit expect_out);
        if (expect_out) exp_q.push_back(b);
        wr(2'd1, {24'd0, b});
    endtask

    function automatic logic [31:0] cw(input logic [1:0] sel, input logic [1:0] mode,
                                       input bit act, input bit fl);
        return {24'd0, act, 1'b0, fl, fl, mode, sel};
    endfunction

    task automatic set_mode(input logic [1:0] mode);
        wr(2'd0, cw(2'd0, mode, 1'b0, 1'b1));
        @(negedge clk);
        mon_cpol = mode[1]; mon_cpha = mode[0]; mon_nb = 0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        s = 32'd0;
        for (int i = 0; i < 6000; i++) begin
            rd(2'd0, s);
            if (s[16]) break;
        end
        chk(req, {31'd0, s[16]}, 32'd1);
    endtask

    task automatic high_len(output int n);
        n = 0;
        while (spi_sclk == 1'b0) @(negedge clk);
        while (spi_sclk == 1'b1) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          n;
        logic [7:0]  pat [4];
        pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h81; pat[3] = 8'h6E;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d);  chk("R1 ctrl", d, 32'h0004_0000);
        rd(2'd2, d);  chk("R1 div", d, 32'd0);
        chk("R1 sclk", {31'd0, spi_sclk}, 32'd0);
        chk("R1 cs", {29'd0, spi_cs}, 32'h7);

        // R4 divisor 7 behaves as 6
        wr(2'd2, 32'd7);
        rd(2'd2, d);  chk("R4 div low bit", d, 32'd6);

        // R2 all four modes, loopback receive
        for (int m = 0; m < 4; m++) begin
            wr(2'd2, 32'd4);
            set_mode(2'(m));
            chk("R3 idle level", {31'd0, spi_sclk}, {31'd0, mon_cpol});
            wr(2'd0, cw(2'd0, 2'(m), 1'b1, 1'b1));
            for (int k = 0; k < 4; k++) send(pat[k] ^ 8'(m), 1'b1);
            wait_done("R10 done after bytes");
            for (int k = 0; k < 4; k++) begin
                rd(2'd1, d);
                chk("R2 rx byte", d, {24'd0, ~(pat[k] ^ 8'(m))});
            end
        end

        // R10 done clears on data write
        send(8'h5A, 1'b1);
        rd(2'd0, d);  chk("R10 done cleared", {31'd0, d[16]}, 32'd0);
        wait_done("R10 done again");
        rd(2'd1, d);  chk("R2 rx 5A", d, 32'h0000_00A5);

        // R4 period: divisor 6 -> high 3, divisor 10 -> high 5
        wr(2'd2, 32'd6);
        set_mode(2'd0);
        wr(2'd0, cw(2'd0, 2'd0, 1'b1, 1'b1));
        send(8'hC3, 1'b1);
        high_len(n);  chk("R4 half of 6", n, 32'd3);
        wait_done("R4 done");
        wr(2'd2, 32'd10);
        send(8'h18, 1'b1);
        high_len(n);  chk("R4 half of 10", n, 32'd5);
        wait_done("R4 done 10");
        rd(2'd1, d);  chk("R2 rx C3", d, 32'h0000_003C);
        rd(2'd1, d);  chk("R2 rx 18", d, 32'h0000_00E7);

        // R6 chip-select selection and polarity (active, no data queued)
        wr(2'd0, 32'h0000_0081);                 chk("R6 sel1", {29'd0, spi_cs}, 32'h5);
        wr(2'd0, 32'h0020_0082);                 chk("R6 sel2 pol0", {29'd0, spi_cs}, 32'h2);
        wr(2'd0, 32'h0000_00C0);                 chk("R6 common pol", {29'd0, spi_cs}, 32'h1);
        wr(2'd0, 32'h0000_0083);                 chk("R6 sel none", {29'd0, spi_cs}, 32'h7);

        // R8/R9 fill, overflow drop, status levels
        set_mode(2'd0);
        for (int k = 0; k < 16; k++) send(8'(k * 7 + 1), 1'b1);
        send(8'hEE, 1'b0);
        rd(2'd0, d);  chk("R9 tx full flag", {31'd0, d[18]}, 32'd0);
        wr(2'd0, cw(2'd0, 2'd0, 1'b1, 1'b0));
        wait_done("R9 done after fill");
        rd(2'd0, d);  chk("R9 rx flags", {29'd0, d[20:18]}, 32'h7);
        chk("R9 rx any", {31'd0, d[17]}, 32'd1);
        for (int k = 0; k < 16; k++) begin
            rd(2'd1, d);
            chk("R8 rx order", d, {24'd0, ~8'(k * 7 + 1)});
        end
        rd(2'd1, d);  chk("R8 empty read", d, 32'd0);
        rd(2'd0, d);  chk("R9 drained", {29'd0, d[20:18], 1'b0} | {31'd0, d[17]}, 32'h2);

        // R7 flush: queued bytes never sent, rx flush empties
        wr(2'd0, cw(2'd0, 2'd0, 1'b0, 1'b0));
        send(8'h11, 1'b0); send(8'h22, 1'b0); send(8'h33, 1'b0);
        wr(2'd0, 32'h0000_0010);
        wr(2'd0, cw(2'd0, 2'd0, 1'b1, 1'b0));
        repeat (40) @(negedge clk);
        rd(2'd0, d);  chk("R7 tx flushed done", {31'd0, d[16]}, 32'd1);
        send(8'h44, 1'b1);
        wait_done("R7 after send");
        wr(2'd0, 32'h0000_00A0);
        rd(2'd0, d);  chk("R7 rx flushed", {31'd0, d[17]}, 32'd0);
        rd(2'd1, d);  chk("R7 rx read zero", d, 32'd0);

        // R11 counted transfer
        wr(2'd0, cw(2'd0, 2'd0, 1'b0, 1'b1));
        wr(2'd3, 32'd2);
        send(8'h9A, 1'b1); send(8'h4B, 1'b1); send(8'h77, 1'b0); send(8'h78, 1'b0);
        wr(2'd0, 32'h0000_0980);
        chk("R11 cs asserted", {29'd0, spi_cs}, 32'h6);
        wait_done("R11 done");
        chk("R11 cs released", {29'd0, spi_cs}, 32'h7);
        repeat (60) @(negedge clk);
        rd(2'd1, d);  chk("R11 rx 1", d, 32'h0000_0065);
        rd(2'd1, d);  chk("R11 rx 2", d, 32'h0000_00B4);
        rd(2'd1, d);  chk("R11 only two", d, 32'd0);
        wr(2'd0, cw(2'd0, 2'd0, 1'b0, 1'b1));

        // R5 zero divisor, then R12 abort
        wr(2'd2, 32'd0);
        wr(2'd0, cw(2'd0, 2'd0, 1'b1, 1'b1));
        send(8'hF0, 1'b0);
        high_len(n);  chk("R5 max half", n, 32'd32768);
        wr(2'd0, cw(2'd0, 2'b10, 1'b0, 1'b1));
        chk("R12 cs idle", {29'd0, spi_cs}, 32'h7);
        chk("R12 sclk idle", {31'd0, spi_sclk}, 32'd1);
        @(negedge clk);
        mon_nb = 0;
        rd(2'd1, d);  chk("R12 no rx", d, 32'd0);

        chk("R2 all bytes seen", exp_q.size(), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule